// File: doc/BRIEF.md
# Micro-operation issue latency controller

This block sits at the issue point of a small in-order micro-operation pipeline. The decoder presents one micro-operation at a time, with a valid strobe, a three-bit class code and a size flag. The block takes the micro-operation when both valid and ready are high. It then holds ready low for as many extra cycles as that class occupies the pipeline, so the decoder cannot issue the next micro-operation early. Operand values, bus transfers and results are not handled here; only the issue timing is.

The cost of a push depends on history. A one-bit record notes whether the most recent memory-class micro-operation stored data, through a push or a write. A push that follows a store is charged the extra bus turnaround; a push after a read, or after reset, is not. A change of flow must refetch from a new address. It costs the longest fixed penalty and raises a one-cycle flush strobe, so the decoder drops whatever it had fetched behind the jump. A free-running cycle counter gives the pipeline a time base. The figures assume no wait states, no bus hold and aligned word data.

The control is a three-state machine. OPEN is the state that accepts. FLUSH is the first penalty cycle of a refetch. STALL covers the remaining held cycles. The transitions are: OPEN to STALL on a taken multi-cycle micro-operation that is not a refetch; OPEN to FLUSH on a taken refetch; FLUSH to STALL or STALL to STALL while cycles remain; FLUSH or STALL to OPEN when the last held cycle ends. A single-cycle micro-operation keeps the machine in OPEN.

Top module: `uop_issue_timer`

## Requirements
- R1: During and after reset, ready is high, the flush strobe is low, the cycle counter reads zero and the store-history bit is clear. A reset applied in the middle of a stall ends that stall.
- R2: Class codes 0 (ALU), 2 (memory write), 6 and 7 (reserved, handled as ALU) take one cycle: ready stays high in the cycle after they are taken.
- R3: Class code 1 (memory read) takes 6 cycles: ready is low for the 5 cycles after it is taken. A read also clears the store-history bit.
- R4: Class code 3 (push) takes 1 cycle when the store-history bit is clear, which is the case after reset or when the last memory-class micro-operation was a read.
- R5: A push takes 5 cycles (ready low for 4) when the last memory-class micro-operation was a push or a write. Classes 0, 4, 5, 6 and 7 leave the history bit unchanged.
- R6: Class code 4 (multiply/divide) takes 8 cycles when the size flag is 0 (byte) and 16 cycles when it is 1 (word).
- R7: Class code 5 (refetch after jump, call, return or loop) takes 9 cycles. The flush strobe is high for exactly one cycle, the first cycle after the micro-operation is taken, and it is low at all other times.
- R8: A valid micro-operation presented while ready is low is discarded. It does not lengthen the stall and does not change the store-history bit.
- R9: The cycle counter starts at zero after reset and rises by one on every clock.
- R10: A micro-operation is taken only on a cycle in which valid and ready are both high. Ready is low from the cycle after a multi-cycle micro-operation is taken through its last cycle, and high again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 1 | Decoder presents a micro-operation |
| uop_class | input | 3 | Class code (0 ALU, 1 read, 2 write, 3 push, 4 mul/div, 5 refetch, 6-7 reserved) |
| uop_wide | input | 1 | Size flag for mul/div: 0 byte, 1 word |
| uop_ready | output | 1 | High when a micro-operation can be taken this cycle |
| flush_pulse | output | 1 | One-cycle strobe telling the decoder to drop its fetched micro-operation |
| cycle_count | output | CNT_W | Free-running cycle counter |

## Verification
The hardest case to reach is the store-history bit, because it never appears at a port. Its value shows only as the length of a later push. The stimulus table therefore chains micro-operations in an order where each push follows a different kind of predecessor: a read, a push, a write, and runs of ALU, multiply and refetch operations placed between a store and the push. Each measured stall then exposes what the hidden bit held. The same method checks two directed cases. In one, a write is held on valid through a whole refetch penalty. In the other, reset is applied inside a long multiply. In both, the push that comes next must cost one cycle.

// File: rtl/uop_issue_pkg.sv
package uop_issue_pkg;

    typedef enum logic [2:0] {
        UC_ALU    = 3'd0,
        UC_RD     = 3'd1,
        UC_WR     = 3'd2,
        UC_PUSH   = 3'd3,
        UC_MULDIV = 3'd4,
        UC_FETCH  = 3'd5,
        UC_RSV6   = 3'd6,
        UC_RSV7   = 3'd7
    } uop_class_e;

    typedef enum logic [1:0] {
        S_OPEN  = 2'd0,
        S_FLUSH = 2'd1,
        S_STALL = 2'd2
    } issue_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/uop_lat_calc.sv
module uop_lat_calc
    import uop_issue_pkg::*;
#(
    parameter int RD_LAT    = 6,
    parameter int PUSH_LAT  = 5,
    parameter int MUL_B_LAT = 8,
    parameter int MUL_W_LAT = 16,
    parameter int FETCH_LAT = 9,
    parameter int LAT_W     = 5
) (
    input  uop_class_e       cls,
    input  logic             wide,
    input  logic             store_hist,
    output logic [LAT_W-1:0] lat,
    output logic             is_fetch
);

    always_comb begin
        lat      = LAT_W'(1);
        is_fetch = 1'b0;
        unique case (cls)
            UC_ALU, UC_WR, UC_RSV6, UC_RSV7: lat = LAT_W'(1);
            UC_RD:     lat = LAT_W'(RD_LAT);
            UC_PUSH:   lat = store_hist ? LAT_W'(PUSH_LAT) : LAT_W'(1);
            UC_MULDIV: lat = wide ? LAT_W'(MUL_W_LAT) : LAT_W'(MUL_B_LAT);
            UC_FETCH: begin
                lat      = LAT_W'(FETCH_LAT);
                is_fetch = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/uop_store_hist.sv
module uop_store_hist
    import uop_issue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  uop_class_e cls,
    output logic       store_hist
);

    logic hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else if (take) begin
            if (cls == UC_WR || cls == UC_PUSH) begin
                hist_q <= 1'b1;
            end else if (cls == UC_RD) begin
                hist_q <= 1'b0;
            end
        end
    end

    assign store_hist = hist_q;

    p_hist_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cls == UC_WR || cls == UC_PUSH)) |=> store_hist);

    p_hist_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == UC_RD) |=> !store_hist);

    p_hist_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(store_hist));

endmodule

// File: rtl/uop_issue_fsm.sv
module uop_issue_fsm
    import uop_issue_pkg::*;
#(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LAT_W-1:0] lat,
    input  logic             is_fetch,
    output logic             ready,
    output logic             flush,
    output logic             take
);

    issue_state_e     st_q, st_d;
    logic [LAT_W-1:0] rem_q, rem_d;

    assign take = valid && ready;

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        unique case (st_q)
            S_OPEN: begin
                if (take && lat > LAT_W'(1)) begin
                    st_d  = is_fetch ? S_FLUSH : S_STALL;
                    rem_d = lat - LAT_W'(2);
                end
            end
            S_FLUSH, S_STALL: begin
                if (rem_q == '0) begin
                    st_d = S_OPEN;
                end else begin
                    st_d  = S_STALL;
                    rem_d = rem_q - LAT_W'(1);
                end
            end
            default: begin
                st_d  = S_OPEN;
                rem_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_OPEN;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        ready = (st_q == S_OPEN);
        flush = (st_q == S_FLUSH);
    end

    p_hold_after_long_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && lat > LAT_W'(1)) |=> !ready);

    p_single_no_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && lat == LAT_W'(1)) |=> ready);

    p_flush_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    p_flush_after_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_fetch) |=> flush);

    p_no_take_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !take);

endmodule

// File: rtl/uop_cycle_ctr.sv
module uop_cycle_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign count = cnt_q;

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count == W'($past(count) + W'(1)));

endmodule

// File: rtl/uop_issue_timer.sv
module uop_issue_timer
    import uop_issue_pkg::*;
#(
    parameter int RD_LAT    = 6,
    parameter int PUSH_LAT  = 5,
    parameter int MUL_B_LAT = 8,
    parameter int MUL_W_LAT = 16,
    parameter int FETCH_LAT = 9,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uop_valid,
    input  logic [2:0]       uop_class,
    input  logic             uop_wide,
    output logic             uop_ready,
    output logic             flush_pulse,
    output logic [CNT_W-1:0] cycle_count
);

    localparam int MAX_LAT = max_of(max_of(max_of(RD_LAT, PUSH_LAT),
                                           max_of(MUL_B_LAT, MUL_W_LAT)), FETCH_LAT);
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    uop_class_e       cls;
    logic             store_hist;
    logic [LAT_W-1:0] lat;
    logic             is_fetch;
    logic             take;

    assign cls = uop_class_e'(uop_class);

    uop_lat_calc #(
        .RD_LAT    (RD_LAT),
        .PUSH_LAT  (PUSH_LAT),
        .MUL_B_LAT (MUL_B_LAT),
        .MUL_W_LAT (MUL_W_LAT),
        .FETCH_LAT (FETCH_LAT),
        .LAT_W     (LAT_W)
    ) u_lat (
        .cls        (cls),
        .wide       (uop_wide),
        .store_hist (store_hist),
        .lat        (lat),
        .is_fetch   (is_fetch)
    );

    uop_store_hist u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .cls        (cls),
        .store_hist (store_hist)
    );

    uop_issue_fsm #(
        .LAT_W (LAT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (uop_valid),
        .lat      (lat),
        .is_fetch (is_fetch),
        .ready    (uop_ready),
        .flush    (flush_pulse),
        .take     (take)
    );

    uop_cycle_ctr #(
        .W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_count)
    );

    p_push_after_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == UC_PUSH && store_hist && PUSH_LAT > 1) |=> !uop_ready);

    p_push_cheap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == UC_PUSH && !store_hist) |=> uop_ready);

endmodule

// File: tb/uop_issue_timer_test.sv
module uop_issue_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uop_valid = 1'b0;
    logic [2:0]  uop_class = 3'd0;
    logic        uop_wide = 1'b0;
    logic        uop_ready;
    logic        flush_pulse;
    logic [15:0] cycle_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uop_issue_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .uop_valid   (uop_valid),
        .uop_class   (uop_class),
        .uop_wide    (uop_wide),
        .uop_ready   (uop_ready),
        .flush_pulse (flush_pulse),
        .cycle_count (cycle_count)
    );

    // vector: {class[2:0], wide, expected ready-low cycles[4:0], expected flush count}
    localparam int NV = 18;
    localparam logic [9:0] VEC [NV] = '{
        {3'd0, 1'b0, 5'd0,  1'b0},  // R2 ALU
        {3'd1, 1'b0, 5'd5,  1'b0},  // R3 read
        {3'd3, 1'b0, 5'd0,  1'b0},  // R4 push after read
        {3'd3, 1'b0, 5'd4,  1'b0},  // R5 push after push
        {3'd2, 1'b0, 5'd0,  1'b0},  // R2 write
        {3'd3, 1'b0, 5'd4,  1'b0},  // R5 push after write
        {3'd0, 1'b0, 5'd0,  1'b0},  // R2 ALU between
        {3'd3, 1'b0, 5'd4,  1'b0},  // R5 ALU kept history
        {3'd1, 1'b0, 5'd5,  1'b0},  // R3 read clears
        {3'd4, 1'b0, 5'd7,  1'b0},  // R6 byte mul/div
        {3'd4, 1'b1, 5'd15, 1'b0},  // R6 word mul/div
        {3'd3, 1'b0, 5'd0,  1'b0},  // R4 push, last memory op was read
        {3'd5, 1'b0, 5'd8,  1'b1},  // R7 refetch
        {3'd2, 1'b0, 5'd0,  1'b0},  // R2 write
        {3'd5, 1'b0, 5'd8,  1'b1},  // R7 refetch
        {3'd4, 1'b1, 5'd15, 1'b0},  // R6 word, history kept
        {3'd3, 1'b0, 5'd4,  1'b0},  // R5 history kept across refetch and mul/div
        {3'd6, 1'b0, 5'd0,  1'b0}   // R2 reserved code
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge. Waits for ready, issues one micro-operation, measures
    // ready-low cycles and flush strobes. With hold set, keeps valid high with
    // class hold_cls during the stall window.
    task automatic issue(input logic [2:0] cls, input logic wide, input int exp_stall,
                         input int exp_flush, input string tag,
                         input bit hold, input logic [2:0] hold_cls);
        int stall = 0;
        int flushes = 0;
        while (!uop_ready) @(negedge clk);
        uop_valid = 1'b1;
        uop_class = cls;
        uop_wide  = wide;
        @(negedge clk);
        if (hold) uop_class = hold_cls;
        else uop_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (flush_pulse) flushes++;
            if (uop_ready) break;
            stall++;
            @(negedge clk);
        end
        uop_valid = 1'b0;
        check(stall == exp_stall, {tag, " stall"}, stall, exp_stall);
        check(flushes == exp_flush, {tag, " flush"}, flushes, exp_flush);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(uop_ready == 1'b1, "R1 ready in reset", uop_ready, 1);
        check(flush_pulse == 1'b0, "R1 flush in reset", flush_pulse, 0);
        check(cycle_count == 16'd0, "R1 count in reset", cycle_count, 0);
        rst_n = 1'b1;

        // R9 counter steps once per clock
        begin
            int c0;
            @(negedge clk);
            c0 = cycle_count;
            check(c0 == 1, "R9 first count", c0, 1);
            repeat (10) @(negedge clk);
            check(cycle_count == 16'(c0 + 10), "R9 count step", cycle_count, c0 + 10);
        end

        // R1 history clear after reset: push costs one cycle
        issue(3'd3, 1'b0, 0, 0, "R1 R4 push after reset", 1'b0, 3'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][9:7], VEC[i][6], int'(VEC[i][5:1]), int'(VEC[i][0]),
                  $sformatf("R10 vector %0d", i), 1'b0, 3'd0);
        end

        // R8 a write held on valid through a refetch penalty is discarded
        issue(3'd1, 1'b0, 5, 0, "R3 read before hold", 1'b0, 3'd0);
        issue(3'd5, 1'b0, 8, 1, "R8 refetch with held write", 1'b1, 3'd2);
        issue(3'd3, 1'b0, 0, 0, "R8 push after discarded write", 1'b0, 3'd0);

        // R8 a push held through a read stall does not extend it
        issue(3'd1, 1'b0, 5, 0, "R8 read with held push", 1'b1, 3'd3);
        issue(3'd3, 1'b0, 0, 0, "R8 push after discarded push", 1'b0, 3'd0);

        // R1 reset in the middle of a long stall
        issue(3'd2, 1'b0, 0, 0, "R2 write before reset", 1'b0, 3'd0);
        while (!uop_ready) @(negedge clk);
        uop_valid = 1'b1;
        uop_class = 3'd4;
        uop_wide  = 1'b1;
        @(negedge clk);
        uop_valid = 1'b0;
        check(uop_ready == 1'b0, "R6 stall started", uop_ready, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(uop_ready == 1'b1, "R1 ready after mid reset", uop_ready, 1);
        check(cycle_count == 16'd0, "R1 count after mid reset", cycle_count, 0);
        rst_n = 1'b1;
        issue(3'd3, 1'b0, 0, 0, "R1 push after mid reset", 1'b0, 3'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule